// File: doc/BRIEF.md
# Toggle Handshake Clock-Domain Crossing

This block moves one data word at a time from a source clock domain to a destination clock domain whose clock has no known phase or frequency relation to it, and returns an acknowledge. Neither direction uses a pulse or a level that has to be withdrawn later. The source flips a request level to announce a word. The destination flips an acknowledge level to confirm that it has taken the word. Each side finds the other's flip by comparing the freshly synchronized level with the value it registered one cycle earlier.

On the source side, a `send_i` strobe while idle latches the word and marks the block busy. The word stays in a holding register, unchanged, until the acknowledge flip comes back. The destination raises `valid_o` for one cycle with the word on `dst_data_o`. The source then raises `done_o` for one cycle and drops `busy_o` on the following cycle. A whole transfer costs a single request flip and a single acknowledge flip, so no return-to-zero phase is needed.

Top module: `toggle_xfer_sync`

## Requirements
- R1: While either reset is asserted, and after both are released with no send, `busy_o`, `done_o` and `valid_o` are 0 and `dst_data_o` is all zeros.
- R2: A `send_i` sampled high while `busy_o` is 0 is accepted. `busy_o` reads 1 from the next source clock cycle on.
- R3: Each accepted send makes `valid_o` high for exactly one destination cycle. In that cycle `dst_data_o` equals the `src_data_i` value sampled with the accepted send.
- R4: A `send_i` sampled while `busy_o` is 1 is ignored. It produces no extra `valid_o` pulse and no extra `done_o` pulse, and it does not change the delivered word.
- R5: `done_o` is high for exactly one source cycle. That cycle falls while `busy_o` is still 1, and `busy_o` reads 0 in the next source cycle.
- R6: Changes on `src_data_i` after acceptance do not alter the delivered word. The held copy stays stable while `busy_o` is 1.
- R7: Every accepted send yields exactly one `valid_o` and one `done_o`, for both directions of the request flip (0 to 1 and 1 to 0). With `send_i` held high, a new transfer starts on the cycle after each `done_o`.
- R8: With two synchronizer stages, `done_o` arrives no later than 4 source cycles plus 4 destination cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| send_i | input | 1 | Request to transfer `src_data_i` |
| src_data_i | input | DATA_W | Word to transfer |
| busy_o | output | 1 | Transfer in flight; sends are ignored |
| done_o | output | 1 | One-cycle pulse: the destination has taken the word |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| valid_o | output | 1 | One-cycle pulse: `dst_data_o` holds a new word |
| dst_data_o | output | DATA_W | Delivered word |

## Verification
Several properties are checked on every clock edge. Busy follows an accepted send and stays set until `done_o`. `done_o` occurs only while busy and clears busy. A busy cycle never flips the request level and never alters the held word. `valid_o` never lasts two cycles, and it always carries the held word.

Other behaviours need the bench's scenarios to show them. These are the one-to-one count of `valid_o` and `done_o` pulses per accepted send, the delivered value against the word presented at acceptance, the silence after an ignored send, the round-trip bound, and the continuous back-to-back flow with `send_i` held high.

// File: rtl/txs_pkg.sv
package txs_pkg;
  // A level flip seen between two consecutive samples marks one event.
  function automatic logic level_flip(input logic now_l, input logic prev_l);
    return now_l ^ prev_l;
  endfunction
endpackage

// File: rtl/txs_sync.sv
module txs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/txs_edge.sv
module txs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic evt_o
);
  import txs_pkg::*;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign evt_o = level_flip(lvl_i, prev_q);
endmodule

// File: rtl/txs_src.sv
module txs_src #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_tgl_i,
  output logic              req_tgl_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              busy_o,
  output logic              done_o
);
  logic ack_s, ack_evt, accept, busy_q, req_q;
  logic [DATA_W-1:0] hold_q;

  txs_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ack_tgl_i), .q_o(ack_s)
  );
  txs_edge u_ack_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(ack_s), .evt_o(ack_evt)
  );

  assign accept = send_i & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      hold_q <= '0;
    end else if (accept) begin
      req_q  <= ~req_q;
      busy_q <= 1'b1;
      hold_q <= data_i;
    end else if (ack_evt) begin
      busy_q <= 1'b0;
    end
  end

  assign req_tgl_o = req_q;
  assign hold_o    = hold_q;
  assign busy_o    = busy_q;
  assign done_o    = ack_evt;
endmodule

// File: rtl/txs_dst.sv
module txs_dst #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              req_evt_o,
  output logic              ack_tgl_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic req_s, req_evt, ack_q, valid_q;
  logic [DATA_W-1:0] data_q;

  txs_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_tgl_i), .q_o(req_s)
  );
  txs_edge u_req_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(req_s), .evt_o(req_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= req_evt;
      if (req_evt) begin
        ack_q  <= ~ack_q;
        data_q <= hold_i;
      end
    end
  end

  assign req_evt_o = req_evt;
  assign ack_tgl_o = ack_q;
  assign valid_o   = valid_q;
  assign data_o    = data_q;
endmodule

// File: rtl/toggle_xfer_sync.sv
module toggle_xfer_sync #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              send_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              valid_o,
  output logic [DATA_W-1:0] dst_data_o
);
  // Named crossing wires, visible to the bound checker.
  logic              req_tgl;
  logic              ack_tgl;
  logic              req_evt;
  logic [DATA_W-1:0] hold_word;

  txs_src #(.DATA_W(DATA_W), .STAGES(STAGES)) u_src (
    .clk(src_clk), .rst_n(src_rst_n), .send_i(send_i), .data_i(src_data_i),
    .ack_tgl_i(ack_tgl), .req_tgl_o(req_tgl), .hold_o(hold_word),
    .busy_o(busy_o), .done_o(done_o)
  );

  txs_dst #(.DATA_W(DATA_W), .STAGES(STAGES)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_n), .req_tgl_i(req_tgl), .hold_i(hold_word),
    .req_evt_o(req_evt), .ack_tgl_o(ack_tgl), .valid_o(valid_o),
    .data_o(dst_data_o)
  );
endmodule

// File: rtl/txs_chk.sv
module txs_chk #(
  parameter int DATA_W = 8
) (
  input logic              src_clk,
  input logic              src_rst_n,
  input logic              dst_clk,
  input logic              dst_rst_n,
  input logic              send_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] dst_data_o,
  input logic              req_tgl,
  input logic              req_evt,
  input logic [DATA_W-1:0] hold_word
);
  // R2: an accepted send sets busy
  a_r2_busy_after_send: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (send_i && !busy_o) |=> busy_o);

  // R4: a busy cycle never flips the request level
  a_r4_no_flip_busy: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    busy_o |=> $stable(req_tgl));

  // R5: busy holds until done
  a_r5_busy_holds: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R5: done only while busy
  a_r5_done_in_busy: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    done_o |-> busy_o);

  // R5: done clears busy on the next cycle
  a_r5_done_clears: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    done_o |=> !busy_o);

  // R6: held word is stable across a busy cycle
  a_r6_hold_stable: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    busy_o |=> $stable(hold_word));

  // R3: valid lasts a single destination cycle
  a_r3_valid_single: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    valid_o |=> !valid_o);

  // R3: the pulse follows a detected request flip
  a_r3_valid_after_evt: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    req_evt |=> valid_o);

  // R6: the delivered word matches the held copy
  a_r6_data_matches: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    valid_o |-> (dst_data_o == hold_word));
endmodule

bind toggle_xfer_sync txs_chk #(.DATA_W(DATA_W)) u_chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n), .dst_clk(dst_clk),
  .dst_rst_n(dst_rst_n), .send_i(send_i), .busy_o(busy_o), .done_o(done_o),
  .valid_o(valid_o), .dst_data_o(dst_data_o), .req_tgl(req_tgl),
  .req_evt(req_evt), .hold_word(hold_word)
);

// File: tb/sim_toggle_xfer_sync.sv
`timescale 1ns/1ps
module sim_toggle_xfer_sync;
  localparam int DATA_W  = 8;
  localparam int SRC_HALF = 10;   // 50 MHz source clock
  localparam int DST_HALF = 13;   // unrelated destination clock
  localparam int RT_LIMIT = 10;   // 4 src + ceil(4*26/20) src cycles, R8

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic send_i = 1'b0;
  logic [DATA_W-1:0] src_data_i = '0;
  logic busy_o, done_o, valid_o;
  logic [DATA_W-1:0] dst_data_o;

  always #(SRC_HALF) src_clk = ~src_clk;
  always #(DST_HALF) dst_clk = ~dst_clk;

  toggle_xfer_sync #(.DATA_W(DATA_W), .STAGES(2)) u0 (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .send_i(send_i),
    .src_data_i(src_data_i), .busy_o(busy_o), .done_o(done_o),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .valid_o(valid_o),
    .dst_data_o(dst_data_o)
  );

  int n_checks = 0, n_fail = 0;
  int valid_cnt = 0, done_cnt = 0;
  logic [DATA_W-1:0] last_word = '0;
  bit finished = 0;

  // Monitors sample away from the active edge.
  always @(negedge dst_clk) if (dst_rst_n && valid_o) begin
    valid_cnt++;
    last_word = dst_data_o;
  end
  always @(negedge src_clk) if (src_rst_n && done_o) done_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Vector table: {ignore-send flag, word, late word}
  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'hA5, 8'h5A},
    {1'b1, 8'h00, 8'hFF},
    {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h3C, 8'hC3},
    {1'b1, 8'h81, 8'h7E},
    {1'b0, 8'h01, 8'h80}
  };

  task automatic xfer(input logic [DATA_W-1:0] word, input logic [DATA_W-1:0] late,
                      input bit try_ignore);
    int v0, d0, n;
    v0 = valid_cnt; d0 = done_cnt;
    @(negedge src_clk);
    send_i = 1'b1; src_data_i = word;
    @(negedge src_clk);
    send_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after send", busy_o, 1);
    src_data_i = late;                       // R6: late change must not matter
    if (try_ignore) send_i = 1'b1;           // R4: send while busy
    n = 1;
    while (!done_o && n < 40) begin
      @(negedge src_clk);
      send_i = 1'b0;
      n++;
    end
    send_i = 1'b0;
    check(done_o == 1'b1, "R5 done seen", done_o, 1);
    check(n <= RT_LIMIT, "R8 round trip", n, RT_LIMIT);
    check(busy_o == 1'b1, "R5 busy during done", busy_o, 1);
    @(negedge src_clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R5 busy clears after done",
          {busy_o, done_o}, 0);
    check(valid_cnt == v0 + 1, "R3 one valid pulse", valid_cnt - v0, 1);
    check(last_word == word, "R6 delivered word", last_word, word);
    repeat (12) @(negedge src_clk);
    check(valid_cnt == v0 + 1 && done_cnt == d0 + 1, "R4 no extra events",
          valid_cnt - v0 + done_cnt - d0, 2);
  endtask

  initial begin
    int v0, d0;
    // R1: reset state
    repeat (3) @(negedge src_clk);
    check(busy_o == 0 && done_o == 0 && valid_o == 0 && dst_data_o == 0,
          "R1 in reset", {busy_o, done_o, valid_o}, 0);
    src_rst_n = 1'b1;
    @(negedge dst_clk); dst_rst_n = 1'b1;
    repeat (6) @(negedge src_clk);
    check(busy_o == 0 && done_o == 0 && valid_o == 0 && dst_data_o == 0 &&
          valid_cnt == 0, "R1 idle after reset", valid_cnt, 0);

    // Table walk; successive entries flip the request both ways (R7)
    for (int i = 0; i < NV; i++)
      xfer(VEC[i][15:8], VEC[i][7:0], VEC[i][16]);
    check(valid_cnt == NV && done_cnt == NV, "R7 one event pair per send",
          valid_cnt, NV);

    // R7: send held high streams transfers back to back
    v0 = valid_cnt; d0 = done_cnt;
    @(negedge src_clk);
    src_data_i = 8'h6E; send_i = 1'b1;
    repeat (80) @(negedge src_clk);
    send_i = 1'b0;
    repeat (30) @(negedge src_clk);
    check(done_cnt - d0 >= 5, "R7 streaming transfers", done_cnt - d0, 5);
    check(valid_cnt - v0 == done_cnt - d0, "R7 valid equals done count",
          valid_cnt - v0, done_cnt - d0);
    check(last_word == 8'h6E, "R3 streamed word", last_word, 8'h6E);
    check(busy_o == 1'b0, "R5 idle after stream", busy_o, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(2 * SRC_HALF * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule